// File: doc/BRIEF.md
# Packed-Pixel Sum of Absolute Differences Accumulator

This functional unit measures how closely a current block of pixels matches a candidate reference block. Each accepted operation carries one row of sixteen unsigned 8-bit pixels from the current block and the matching row from the reference block, both packed into 128-bit words. Every lane computes the magnitude of its pixel difference. A registered adder tree sums the sixteen magnitudes, and the row total goes into a running accumulator. Subtract, magnitude and accumulate are fused, so one issue does the work of sixteen scalar pixel operations.

A 16x16 block takes sixteen row issues. The unit counts accepted rows. Two cycles after the sixteenth row is accepted, it raises a one-cycle done flag, and the complete block total is on the result output at the same time. A start input marks the first row of a block. The first row after reset, and the first row after a finished block, also open a new block without the start input. Rows can be issued back to back, one per clock, or with idle cycles between them.

Top module: `sad_simd_acc`

## Requirements
- R1: Lane i takes bits [8i+7:8i] of `cur_row` and of `ref_row` (lane 0 is the lowest byte). It contributes |cur - ref| as an unsigned 8-bit magnitude, whichever of the two pixels is larger.
- R2: Each accepted row adds the sum of its sixteen lane magnitudes to the running total on `sad_out`. The new total is visible after the second rising edge following acceptance.
- R3: `sad_out` is 16 bits wide and holds the largest block total, 16 x 16 x 255 = 65280, without wrapping.
- R4: The first row of a block replaces the total with that row's sum instead of adding to it. A row opens a block when `blk_start` is high with it, when it is the first row after reset, or when it is the first row after a completed 16-row block.
- R5: `sad_done` is high for exactly one cycle. It rises two rising edges after the 16th row of a block is accepted, with the full block total on `sad_out` in that same cycle, and it is low at every other time.
- R6: A row is accepted only on an edge where `in_valid` and `in_ready` are both high. While `in_valid` is low, the values on `cur_row`, `ref_row` and `blk_start` change neither the total nor the row count.
- R7: `in_ready` is low during reset and high from the first rising edge after reset. Rows can then be accepted on consecutive clocks with no lost or doubled row.
- R8: A row that arrives with `blk_start` high in the middle of a block discards the partial total and restarts the row count, so that row is row 1 of a new block.
- R9: During reset `sad_out` is 0 and `sad_done` is 0.
- R10: Between accepted rows, and after done, `sad_out` keeps its last value until the next accepted row updates it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Row operands present |
| in_ready | output | 1 | Unit can accept a row |
| blk_start | input | 1 | Row is the first of a new block |
| cur_row | input | 128 | Sixteen current-block pixels, lane 0 in the lowest byte |
| ref_row | input | 128 | Sixteen reference-block pixels, same lane order |
| sad_out | output | 16 | Running or final block total |
| sad_done | output | 1 | One-cycle flag: `sad_out` is a complete block total |

## Verification
The bench places one pixel pair in each lane in turn, with the reference pixel larger and then smaller. A wrong lane slice or a signed subtraction would show up as a wrong or wrapped magnitude. Full blocks are streamed back to back and with idle gaps that carry junk data and a stray start. This catches a counter that advances on idle cycles, a done flag that comes one row early or late or lasts two cycles, and an accumulator that drifts while idle. An all-maximum block checks that the accumulator is wide enough. A start in the middle of a block, and a row without start right after done, check that the unit clears the total at those points instead of adding the new row to stale data.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int DEF_PIX_W = 8;
    localparam int DEF_LANES = 16;
    localparam int DEF_ROWS  = 16;

    // Bits needed to hold n full-scale pixel magnitudes.
    function automatic int sum_width(input int pix_w, input int n);
        return $clog2(n * ((1 << pix_w) - 1) + 1);
    endfunction

endpackage

// File: rtl/sad_lane_absdiff.sv
module sad_lane_absdiff #(
    parameter int PIX_W = sad_pkg::DEF_PIX_W
) (
    input  logic [PIX_W-1:0] cur_px,
    input  logic [PIX_W-1:0] prv_px,
    output logic [PIX_W-1:0] mag
);

    logic [PIX_W:0] diff_w;

    always_comb begin
        diff_w = {1'b0, cur_px} - {1'b0, prv_px};
        if (diff_w[PIX_W]) begin
            mag = PIX_W'(~diff_w + 1'b1);
        end else begin
            mag = diff_w[PIX_W-1:0];
        end
    end

    // R1: magnitude bridges the two pixels
    always_comb begin
        p_mag_match_r1: assert ((cur_px >= prv_px) ? (cur_px == prv_px + mag)
                                                   : (prv_px == cur_px + mag));
    end

endmodule

// File: rtl/sad_row_reducer.sv
module sad_row_reducer #(
    parameter int PIX_W = sad_pkg::DEF_PIX_W,
    parameter int LANES = sad_pkg::DEF_LANES
) (
    input  logic [PIX_W*LANES-1:0]                         cur_row,
    input  logic [PIX_W*LANES-1:0]                         prv_row,
    output logic [sad_pkg::sum_width(PIX_W, LANES)-1:0]    row_sum
);

    localparam int SUM_W = sad_pkg::sum_width(PIX_W, LANES);
    localparam int NODES = 2 * LANES - 1;

    // Heap-ordered tree: node k adds children 2k+1 and 2k+2, leaves at the tail.
    logic [SUM_W-1:0] node [NODES];
    logic [PIX_W-1:0] lane_mag [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sad_lane_absdiff #(.PIX_W(PIX_W)) u_lane (
            .cur_px (cur_row[g*PIX_W +: PIX_W]),
            .prv_px (prv_row[g*PIX_W +: PIX_W]),
            .mag    (lane_mag[g])
        );
        assign node[LANES-1+g] = SUM_W'(lane_mag[g]);
    end

    for (genvar k = 0; k < LANES - 1; k++) begin : g_node
        assign node[k] = node[2*k+1] + node[2*k+2];
    end

    assign row_sum = node[0];

endmodule

// File: rtl/sad_row_tracker.sv
module sad_row_tracker #(
    parameter int ROWS  = sad_pkg::DEF_ROWS,
    parameter int CNT_W = $clog2(ROWS)
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             start,
    output logic             is_first,
    output logic             is_last,
    output logic [CNT_W-1:0] cnt_d
);

    logic [CNT_W-1:0] index_w;

    always_comb begin
        index_w  = start ? '0 : cnt_q;
        is_first = (index_w == '0);
        is_last  = (index_w == CNT_W'(ROWS - 1));
        cnt_d    = is_last ? '0 : index_w + 1'b1;
    end

endmodule

// File: rtl/sad_simd_acc.sv
module sad_simd_acc #(
    parameter int PIX_W = sad_pkg::DEF_PIX_W,
    parameter int LANES = sad_pkg::DEF_LANES,
    parameter int ROWS  = sad_pkg::DEF_ROWS
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           in_valid,
    output logic                                           in_ready,
    input  logic                                           blk_start,
    input  logic [PIX_W*LANES-1:0]                         cur_row,
    input  logic [PIX_W*LANES-1:0]                         ref_row,
    output logic [sad_pkg::sum_width(PIX_W, LANES*ROWS)-1:0] sad_out,
    output logic                                           sad_done
);

    localparam int SUM_W   = sad_pkg::sum_width(PIX_W, LANES);
    localparam int ACC_W   = sad_pkg::sum_width(PIX_W, LANES * ROWS);
    localparam int CNT_W   = $clog2(ROWS);
    localparam int ROW_MAX = LANES * ((1 << PIX_W) - 1);
    localparam int BLK_MAX = ROWS * ROW_MAX;

    typedef struct packed {
        logic             ready;
        logic             s1_valid;
        logic             s1_first;
        logic             s1_last;
        logic [SUM_W-1:0] s1_sum;
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
        logic             done;
    } state_t;

    state_t st_q, st_d;

    logic [SUM_W-1:0] row_sum_w;
    logic             first_w, last_w;
    logic [CNT_W-1:0] cnt_next_w;
    logic             accept_w;

    sad_row_reducer #(.PIX_W(PIX_W), .LANES(LANES)) u_reduce (
        .cur_row (cur_row),
        .prv_row (ref_row),
        .row_sum (row_sum_w)
    );

    sad_row_tracker #(.ROWS(ROWS), .CNT_W(CNT_W)) u_track (
        .cnt_q    (st_q.cnt),
        .start    (blk_start),
        .is_first (first_w),
        .is_last  (last_w),
        .cnt_d    (cnt_next_w)
    );

    assign accept_w = in_valid & st_q.ready;

    always_comb begin
        st_d          = st_q;
        st_d.ready    = 1'b1;
        st_d.s1_valid = accept_w;
        st_d.done     = 1'b0;
        if (accept_w) begin
            st_d.s1_first = first_w;
            st_d.s1_last  = last_w;
            st_d.s1_sum   = row_sum_w;
            st_d.cnt      = cnt_next_w;
        end
        if (st_q.s1_valid) begin
            st_d.acc  = (st_q.s1_first ? '0 : st_q.acc) + ACC_W'(st_q.s1_sum);
            st_d.done = st_q.s1_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = st_q.ready;
    assign sad_out  = st_q.acc;
    assign sad_done = st_q.done;

    // R5: done never lasts two cycles
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sad_done |=> !sad_done);

    // R6 / R10: no accepted row in flight leaves the total untouched
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.s1_valid |=> $stable(sad_out));

    // R4: a block-opening row replaces the total
    p_first_replaces_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s1_valid && st_q.s1_first) |=> (sad_out == ACC_W'($past(st_q.s1_sum))));

    // R3: the total never exceeds the full-scale block sum
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1_valid |-> ((int'(st_q.s1_first ? '0 : st_q.acc) + int'(st_q.s1_sum)) <= BLK_MAX));

    // R2: a registered row sum stays within sixteen full-scale lanes
    p_row_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1_valid |-> (int'(st_q.s1_sum) <= ROW_MAX));

endmodule

// File: tb/sad_simd_acc_bench.sv
`timescale 1ns/1ps
module sad_simd_acc_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         blk_start = 1'b0;
    logic [127:0] cur_row = '0;
    logic [127:0] ref_row = '0;
    logic         in_ready;
    logic [15:0]  sad_out;
    logic         sad_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sad_simd_acc u_sad_simd_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .blk_start (blk_start),
        .cur_row   (cur_row),
        .ref_row   (ref_row),
        .sad_out   (sad_out),
        .sad_done  (sad_done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rowsad(input logic [127:0] a, input logic [127:0] b);
        int s = 0;
        for (int i = 0; i < 16; i++) begin
            int x = int'(a[i*8 +: 8]);
            int y = int'(b[i*8 +: 8]);
            s += (x > y) ? x - y : y - x;
        end
        return s;
    endfunction

    function automatic logic [127:0] mkrow(input int r, input int seed);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(r*37 + i*11 + seed*71 + i*r);
        return v;
    endfunction

    task automatic drive(input logic [127:0] c, input logic [127:0] p, input bit st);
        @(negedge clk);
        in_valid = 1'b1; blk_start = st; cur_row = c; ref_row = p;
    endtask

    // Idle cycles carry junk data and a stray start that must be ignored (R6).
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0; blk_start = 1'b1;
            cur_row = {4{32'hDEAD_BEEF}} ^ 128'(k); ref_row = {4{32'h1357_9BDF}};
        end
    endtask

    // Last row already driven: check done timing and held total.
    task automatic finish_block(input int exp, input string req);
        idle(1);
        chk({req, " R5 done not early"}, sad_done, 0);
        idle(1);
        chk({req, " R5 done raised"}, sad_done, 1);
        chk({req, " R2 block total"}, sad_out, exp);
        idle(1);
        chk({req, " R5 done one cycle"}, sad_done, 0);
        chk({req, " R10 total held after done"}, sad_out, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 reset sad_out", sad_out, 0);
        chk("R9 reset sad_done", sad_done, 0);
        chk("R7 ready low in reset", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 ready after reset", in_ready, 1);
    endtask

    task automatic t_lane_map();
        for (int k = 0; k < 16; k++) begin
            logic [127:0] c, p;
            for (int i = 0; i < 16; i++) begin
                c[i*8 +: 8] = 8'(i*9 + 3);
                p[i*8 +: 8] = 8'(i*9 + 3);
            end
            if (k % 2 == 0) begin c[k*8 +: 8] = 8'd10;  p[k*8 +: 8] = 8'd250; end
            else            begin c[k*8 +: 8] = 8'd250; p[k*8 +: 8] = 8'd10;  end
            drive(c, p, 1'b1);
            idle(2);
            chk($sformatf("R1 lane %0d magnitude", k), sad_out, 240);
        end
    endtask

    task automatic t_stream_block(input int sc, input int sr);
        int exp = 0;
        for (int r = 0; r < 16; r++) begin
            drive(mkrow(r, sc), mkrow(r + 3, sr), r == 0);
            exp += rowsad(mkrow(r, sc), mkrow(r + 3, sr));
        end
        finish_block(exp, "R7 back-to-back");
    endtask

    task automatic t_gap_block();
        int exp = 0;
        for (int r = 0; r < 16; r++) begin
            drive(mkrow(r, 5), mkrow(15 - r, 9), r == 0);
            exp += rowsad(mkrow(r, 5), mkrow(15 - r, 9));
            if (r < 15) begin
                idle(2);
                chk("R2 running total", sad_out, exp);
                chk("R5 no done mid-block", sad_done, 0);
                idle(2);
                chk("R6 idle junk ignored", sad_out, exp);
            end
        end
        finish_block(exp, "R6 gapped");
    endtask

    task automatic t_max_block();
        for (int r = 0; r < 16; r++) begin
            if (r % 2 == 0) drive({16{8'hFF}}, '0, r == 0);
            else            drive('0, {16{8'hFF}}, 1'b0);
        end
        finish_block(65280, "R3 full scale");
    endtask

    task automatic t_restart();
        int exp = 0;
        for (int r = 0; r < 5; r++) begin
            drive(mkrow(r, 2), mkrow(r, 8), r == 0);
            exp += rowsad(mkrow(r, 2), mkrow(r, 8));
        end
        idle(2);
        chk("R2 partial total", sad_out, exp);
        drive(mkrow(40, 1), mkrow(41, 4), 1'b1);
        exp = rowsad(mkrow(40, 1), mkrow(41, 4));
        idle(2);
        chk("R8 restart replaces total", sad_out, exp);
        for (int r = 1; r < 16; r++) begin
            drive(mkrow(r, 6), mkrow(r, 12), 1'b0);
            exp += rowsad(mkrow(r, 6), mkrow(r, 12));
        end
        finish_block(exp, "R8 restarted count");
    endtask

    task automatic t_auto_open();
        int e;
        drive(mkrow(7, 3), mkrow(2, 11), 1'b0);
        e = rowsad(mkrow(7, 3), mkrow(2, 11));
        idle(2);
        chk("R4 row after done opens block", sad_out, e);
    endtask

    initial begin
        t_reset();
        t_auto_open();
        t_lane_map();
        t_stream_block(1, 4);
        t_auto_open();
        t_stream_block(13, 2);
        t_gap_block();
        t_max_block();
        t_restart();
        t_auto_open();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule